// File: doc/BRIEF.md
# DDR2/DDR3 Power-Up Command Sequencer

This block walks a DDR2 or DDR3 SDRAM from power-on to normal operation. After a start pulse it emits the initialisation commands one at a time on a valid/ready command port: each command is an opcode and, for extended mode register writes, a bank-select address. A downstream controller turns each token into pin activity. Between selected steps the sequencer counts out settling delays in clock cycles. The cycle counts come from the clock rate in kHz and the delays in microseconds, both given as parameters.

At start the block captures the memory type and the address geometry. The geometry is the column-count field, the row-count field, the decode mode, the bus width and a legacy-decoder flag. From these it computes the bit position of the bank-select field. DDR2 also needs two configuration flags raised and lowered around particular commands: one for the DLL reset and one for the driver calibration default. The block drives both flags as outputs. When the dummy write at the end has been taken, the block raises a one-cycle pulse that lets the refresh rate be loaded. A done flag then stays high until the next start.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: After reset, or when reset is applied in the middle of a sequence, cmd_valid, busy, done, rate_load, dll_reset and ocd_default are all low.
- R2: Opcode encoding on cmd_op: 0 no-op, 1 precharge all, 2 mode register write, 3 extended mode register write, 4 auto-refresh, 5 ZQ calibration, 6 enter normal mode, 7 dummy write. With ddr3_sel low at start, the accepted opcodes are, in order: 0,0,1,3,3,3,2,1,4,4,2,3,3,6,7. The extended writes target banks 2,3,1,1,1.
- R3: In DDR2, dll_reset is high while the first mode register write, the second precharge-all and both auto-refreshes are accepted. It is low for the second mode register write. ocd_default is high for the fourth extended write and low for the fifth. In DDR3 both flags stay low.
- R4: With ddr3_sel high at start, the accepted opcodes are 0,0,3,3,3,2,5,6,7. The extended writes target banks 2,3,1.
- R5: Each wait of W cycles, with W = ceil(us × CLK_KHZ / 1000), makes the next command appear exactly W+2 cycles after the preceding command is accepted. The waits are DDR2_PWR_US after the first DDR2 no-op, DDR3_PWR_US after the first DDR3 no-op, and DDR3_DLL_US after the DDR3 mode register write.
- R6: An extended write shows cmd_addr = bank << S, where S = cfg_col + 9 + (cfg_row + 11 when decode is sequential, i.e. cfg_interleave low) + (2 if cfg_bus16 else 1). Every other command shows cmd_addr = 0.
- R7: With cfg_legacy high, the row term is always included in S, whatever cfg_interleave is.
- R8: A presented command keeps cmd_op and cmd_addr unchanged until cmd_ready is high. Each acceptance advances exactly one command, so the full list is seen under any ready pattern.
- R9: rate_load pulses for exactly one cycle, two cycles after the dummy write is accepted, in the cycle that done first reads high. done then stays high, with no commands, until the next start. It reads low in the cycle after that start.
- R10: A start pulse while busy is ignored. Neither the command list nor the latched memory type changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a sequence when idle |
| ddr3_sel | input | 1 | 1 selects DDR3, 0 DDR2; captured at start |
| cfg_col | input | 2 | Column-count field |
| cfg_row | input | 2 | Row-count field |
| cfg_interleave | input | 1 | 1 selects interleaved bank decode |
| cfg_bus16 | input | 1 | 1 for a 16-bit data bus, 0 for 32-bit |
| cfg_legacy | input | 1 | 1 when the decoder predates interleaved decode |
| cmd_ready | input | 1 | Downstream accepts the presented command |
| cmd_valid | output | 1 | A command is presented |
| cmd_op | output | 3 | Command opcode (encoding in R2) |
| cmd_addr | output | ADDR_W | Bank-select address |
| dll_reset | output | 1 | DLL-reset configuration flag |
| ocd_default | output | 1 | Driver calibration default flag |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete |
| rate_load | output | 1 | One-cycle pulse to load the refresh rate |

## Verification
A wrong step index shows at once as a wrong opcode or bank in the next accepted command. A mis-counted wait shows as a gap that is off by one or more cycles, measured from the acceptance of the prior command to the presentation of the next. A wrong offset computation is visible on the first extended write, about W+4 cycles after start. Flag sequencing errors surface on the command that the flag must bracket. A handshake fault shows either as a changed token during a stall or as a command that is missing from or repeated in the accepted list.

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq #(
  parameter int CLK_KHZ     = 250000,
  parameter int DDR2_PWR_US = 200,
  parameter int DDR3_PWR_US = 500,
  parameter int DDR3_DLL_US = 50,
  parameter int ADDR_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ddr3_sel,
  input  logic [1:0]        cfg_col,
  input  logic [1:0]        cfg_row,
  input  logic              cfg_interleave,
  input  logic              cfg_bus16,
  input  logic              cfg_legacy,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              dll_reset,
  output logic              ocd_default,
  output logic              busy,
  output logic              done,
  output logic              rate_load
);

  localparam int W_PWR2 = (DDR2_PWR_US * CLK_KHZ + 999) / 1000;
  localparam int W_PWR3 = (DDR3_PWR_US * CLK_KHZ + 999) / 1000;
  localparam int W_DLL  = (DDR3_DLL_US * CLK_KHZ + 999) / 1000;
  localparam int W_BIG  = (W_PWR2 > W_PWR3) ? W_PWR2 : W_PWR3;
  localparam int W_MAX  = (W_BIG > W_DLL) ? W_BIG : W_DLL;
  localparam int CNT_W  = $clog2(W_MAX + 1) + 1;

  localparam logic [2:0] OP_NOP  = 3'd0;
  localparam logic [2:0] OP_PALL = 3'd1;
  localparam logic [2:0] OP_MRS  = 3'd2;
  localparam logic [2:0] OP_EMRS = 3'd3;
  localparam logic [2:0] OP_REF  = 3'd4;
  localparam logic [2:0] OP_ZQ   = 3'd5;
  localparam logic [2:0] OP_NORM = 3'd6;
  localparam logic [2:0] OP_WR   = 3'd7;

  typedef enum logic [1:0] {K_CMD, K_WAIT, K_FLAG, K_END} kind_t;
  typedef struct packed {
    kind_t      kind;
    logic [2:0] op;
    logic [1:0] arg;
  } step_t;

  function automatic step_t step_at(input logic d3, input logic [4:0] i);
    step_t s;
    s = '{K_END, OP_NOP, 2'd0};
    if (!d3) begin
      case (i)
        5'd0, 5'd2:          s = '{K_CMD,  OP_NOP,  2'd0};
        5'd1:                s = '{K_WAIT, OP_NOP,  2'd0};
        5'd3, 5'd9:          s = '{K_CMD,  OP_PALL, 2'd0};
        5'd4:                s = '{K_CMD,  OP_EMRS, 2'd2};
        5'd5:                s = '{K_CMD,  OP_EMRS, 2'd3};
        5'd6, 5'd15, 5'd17:  s = '{K_CMD,  OP_EMRS, 2'd1};
        5'd7:                s = '{K_FLAG, 3'd1,    2'd0};
        5'd12:               s = '{K_FLAG, 3'd0,    2'd0};
        5'd14:               s = '{K_FLAG, 3'd1,    2'd1};
        5'd16:               s = '{K_FLAG, 3'd0,    2'd1};
        5'd8, 5'd13:         s = '{K_CMD,  OP_MRS,  2'd0};
        5'd10, 5'd11:        s = '{K_CMD,  OP_REF,  2'd0};
        5'd18:               s = '{K_CMD,  OP_NORM, 2'd0};
        5'd19:               s = '{K_CMD,  OP_WR,   2'd0};
        default:             s = '{K_END,  OP_NOP,  2'd0};
      endcase
    end else begin
      case (i)
        5'd0, 5'd2:  s = '{K_CMD,  OP_NOP,  2'd0};
        5'd1:        s = '{K_WAIT, OP_NOP,  2'd0};
        5'd3:        s = '{K_CMD,  OP_EMRS, 2'd2};
        5'd4:        s = '{K_CMD,  OP_EMRS, 2'd3};
        5'd5:        s = '{K_CMD,  OP_EMRS, 2'd1};
        5'd6:        s = '{K_CMD,  OP_MRS,  2'd0};
        5'd7:        s = '{K_WAIT, OP_NOP,  2'd1};
        5'd8:        s = '{K_CMD,  OP_ZQ,   2'd0};
        5'd9:        s = '{K_CMD,  OP_NORM, 2'd0};
        5'd10:       s = '{K_CMD,  OP_WR,   2'd0};
        default:     s = '{K_END,  OP_NOP,  2'd0};
      endcase
    end
    return s;
  endfunction

  logic             busy_q, done_q, d3_q, dll_q, ocd_q, rl_q;
  logic [4:0]       idx_q, off_q;
  logic [CNT_W-1:0] cnt_q;

  step_t            cur;
  logic             nxt_wait, advance;
  logic [CNT_W-1:0] nxt_len;
  logic [4:0]       off_calc;

  assign cur      = step_at(d3_q, idx_q);
  assign nxt_wait = step_at(d3_q, idx_q + 5'd1).kind == K_WAIT;
  assign nxt_len  = (idx_q == 5'd0) ? (d3_q ? CNT_W'(W_PWR3) : CNT_W'(W_PWR2))
                                    : CNT_W'(W_DLL);

  assign off_calc = 5'(cfg_col) + 5'd9
                  + ((cfg_legacy || !cfg_interleave) ? 5'(cfg_row) + 5'd11 : 5'd0)
                  + (cfg_bus16 ? 5'd2 : 5'd1);

  assign cmd_valid   = busy_q && cur.kind == K_CMD;
  assign cmd_op      = cmd_valid ? cur.op : OP_NOP;
  assign cmd_addr    = (cmd_valid && cur.op == OP_EMRS) ? (ADDR_W'(cur.arg) << off_q) : '0;
  assign dll_reset   = dll_q;
  assign ocd_default = ocd_q;
  assign busy        = busy_q;
  assign done        = done_q;
  assign rate_load   = rl_q;

  assign advance = busy_q && ((cur.kind == K_CMD && cmd_ready) ||
                              (cur.kind == K_WAIT && cnt_q == '0) ||
                              (cur.kind == K_FLAG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      d3_q   <= 1'b0;
      dll_q  <= 1'b0;
      ocd_q  <= 1'b0;
      rl_q   <= 1'b0;
      idx_q  <= '0;
      off_q  <= '0;
      cnt_q  <= '0;
    end else begin
      rl_q <= 1'b0;
      if (!busy_q && start) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        d3_q   <= ddr3_sel;
        dll_q  <= 1'b0;
        ocd_q  <= 1'b0;
        idx_q  <= '0;
        cnt_q  <= '0;
        off_q  <= off_calc;
      end else if (busy_q) begin
        if (cur.kind == K_END) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rl_q   <= 1'b1;
        end else begin
          if (cur.kind == K_WAIT && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          if (cur.kind == K_FLAG) begin
            if (cur.arg[0]) ocd_q <= cur.op[0];
            else            dll_q <= cur.op[0];
          end
          if (advance) begin
            idx_q <= idx_q + 5'd1;
            if (nxt_wait) cnt_q <= nxt_len;
          end
        end
      end
    end
  end

  // R5
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cur.kind == K_WAIT && cnt_q > CNT_W'(1)) |=> !cmd_valid);

  // R8
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_addr)));

  // R9
  rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_load |-> (done && !busy && !cmd_valid));

  // R9
  rate_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_load |=> !rate_load);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && !cmd_valid));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_q && cur.kind != K_END) |=> (busy_q && $stable(d3_q) && $stable(off_q)));

  // R3
  ddr3_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && d3_q) |-> (!dll_q && !ocd_q));

endmodule

// File: tb/ddr_pwrup_seq_tb.sv
module ddr_pwrup_seq_tb;

  localparam int CLK_KHZ = 100;
  localparam int W2 = 20;
  localparam int W3 = 50;
  localparam int WD = 5;
  localparam int NV = 6;

  // [15] ddr3 [14] legacy [13] interleave [12] bus16 [11:10] row [9:8] col
  // [7:6] ready pattern [5] start while busy [4:0] expected bank offset
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd1, 2'd0, 1'b0, 5'd23},
    {1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 2'd2, 2'd0, 1'b0, 5'd13},
    {1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 2'd0, 2'd1, 1'b0, 5'd25},
    {1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 2'd2, 1'b1, 5'd24},
    {1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 2'd3, 2'd1, 1'b1, 5'd13},
    {1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 2'd2, 1'b0, 5'd21}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ddr3_sel = 1'b0;
  logic [1:0]  cfg_col = '0;
  logic [1:0]  cfg_row = '0;
  logic        cfg_interleave = 1'b0;
  logic        cfg_bus16 = 1'b0;
  logic        cfg_legacy = 1'b0;
  logic        cmd_ready = 1'b0;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_addr;
  logic        dll_reset, ocd_default, busy, done, rate_load;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ddr_pwrup_seq #(.CLK_KHZ(CLK_KHZ), .ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ddr3_sel(ddr3_sel),
    .cfg_col(cfg_col), .cfg_row(cfg_row), .cfg_interleave(cfg_interleave),
    .cfg_bus16(cfg_bus16), .cfg_legacy(cfg_legacy), .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .dll_reset(dll_reset), .ocd_default(ocd_default), .busy(busy),
    .done(done), .rate_load(rate_load)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_cmd(input logic d3, input int i);
    logic [2:0] op;
    logic [1:0] bk;
    op = 3'd0; bk = 2'd0;
    if (!d3) begin
      case (i)
        0, 1: op = 3'd0;
        2, 7: op = 3'd1;
        3: begin op = 3'd3; bk = 2'd2; end
        4: begin op = 3'd3; bk = 2'd3; end
        5, 11, 12: begin op = 3'd3; bk = 2'd1; end
        6, 10: op = 3'd2;
        8, 9: op = 3'd4;
        13: op = 3'd6;
        14: op = 3'd7;
        default: op = 3'd0;
      endcase
    end else begin
      case (i)
        0, 1: op = 3'd0;
        2: begin op = 3'd3; bk = 2'd2; end
        3: begin op = 3'd3; bk = 2'd3; end
        4: begin op = 3'd3; bk = 2'd1; end
        5: op = 3'd2;
        6: op = 3'd5;
        7: op = 3'd6;
        8: op = 3'd7;
        default: op = 3'd0;
      endcase
    end
    return {op, bk};
  endfunction

  task automatic run_vec(input logic [15:0] v);
    logic        d3, sb;
    logic [1:0]  rmode;
    logic [4:0]  eoff;
    logic [2:0]  a_op [16];
    logic [31:0] a_addr [16];
    logic        a_dll [16];
    logic        a_ocd [16];
    int          a_n [16];
    int          p_n [16];
    int nc, ncmd, rl_n, rl_cnt, n;
    logic prev_v, prev_r, rdy, fin;
    logic [2:0]  prev_op;
    logic [31:0] prev_addr;
    string tag;
    d3 = v[15]; sb = v[5]; rmode = v[7:6]; eoff = v[4:0];
    tag = v[14] ? "R7" : "R6";
    @(negedge clk);
    ddr3_sel = d3; cfg_legacy = v[14]; cfg_interleave = v[13];
    cfg_bus16 = v[12]; cfg_row = v[11:10]; cfg_col = v[9:8];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0 && busy == 1'b1, "R9 done clears after start", {done, busy}, 2'b01);
    nc = 0; rl_n = -1; rl_cnt = 0; prev_v = 1'b0; prev_r = 1'b0; fin = 1'b0;
    prev_op = '0; prev_addr = '0;
    n = 0;
    while (!fin && n < 2000) begin
      if (n > 0) @(negedge clk);
      if (sb && n == 8) begin start = 1'b1; ddr3_sel = ~d3; end
      if (sb && n == 9) start = 1'b0;
      if (prev_v && !prev_r)
        chk(cmd_valid && cmd_op == prev_op && cmd_addr == prev_addr,
            "R8 command held while not ready", {cmd_op, cmd_addr}, {prev_op, prev_addr});
      if (cmd_valid && !(prev_v && !prev_r) && nc < 16) p_n[nc] = n;
      case (rmode)
        2'd0: rdy = 1'b1;
        2'd1: rdy = n[0];
        default: rdy = (n % 4) == 3;
      endcase
      cmd_ready = rdy;
      if (cmd_valid && rdy && nc < 16) begin
        a_op[nc] = cmd_op; a_addr[nc] = cmd_addr;
        a_dll[nc] = dll_reset; a_ocd[nc] = ocd_default; a_n[nc] = n;
        nc++;
      end
      if (rate_load) begin
        rl_cnt++;
        if (rl_n < 0) rl_n = n;
        chk(done == 1'b1, "R9 done high with rate_load", done, 1);
      end
      if (rl_n >= 0 && n == rl_n + 3) fin = 1'b1;
      prev_v = cmd_valid; prev_r = rdy; prev_op = cmd_op; prev_addr = cmd_addr;
      n++;
    end
    cmd_ready = 1'b0;
    ncmd = d3 ? 9 : 15;
    chk(nc == ncmd, d3 ? "R4 command count" : "R2 command count", nc, ncmd);
    chk(fin == 1'b1, "R9 sequence completed", fin, 1);
    if (nc == ncmd) begin
      for (int i = 0; i < ncmd; i++) begin
        logic [4:0] e;
        logic [31:0] ea;
        e = exp_cmd(d3, i);
        ea = (e[4:2] == 3'd3) ? (32'(e[1:0]) << eoff) : 32'd0;
        chk(a_op[i] == e[4:2], d3 ? "R4 opcode order" : "R2 opcode order", a_op[i], e[4:2]);
        chk(a_addr[i] == ea, tag, a_addr[i], ea);
        if (!d3) begin
          chk(a_dll[i] == (i >= 6 && i <= 9), "R3 dll_reset", a_dll[i], (i >= 6 && i <= 9));
          chk(a_ocd[i] == (i == 11), "R3 ocd_default", a_ocd[i], (i == 11));
        end else begin
          chk(!a_dll[i] && !a_ocd[i], "R3 flags low in DDR3", {a_dll[i], a_ocd[i]}, 0);
        end
      end
      chk(p_n[1] - a_n[0] == (d3 ? W3 : W2) + 2, "R5 power-up wait",
          p_n[1] - a_n[0], (d3 ? W3 : W2) + 2);
      if (d3) chk(p_n[6] - a_n[5] == WD + 2, "R5 DLL wait", p_n[6] - a_n[5], WD + 2);
      chk(rl_n == a_n[ncmd-1] + 2, "R9 rate_load timing", rl_n, a_n[ncmd-1] + 2);
    end
    chk(rl_cnt == 1, "R9 single rate_load pulse", rl_cnt, 1);
    if (sb) chk(nc == ncmd, "R10 start while busy ignored", nc, ncmd);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({cmd_valid, busy, done, rate_load, dll_reset, ocd_default} == 6'b0,
        "R1 reset state", {cmd_valid, busy, done, rate_load, dll_reset, ocd_default}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_valid == 1'b0 && busy == 1'b0, "R1 idle after reset", {cmd_valid, busy}, 0);

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    repeat (20) @(negedge clk);
    chk(done == 1'b1 && cmd_valid == 1'b0 && rate_load == 1'b0,
        "R9 done persists while idle", {done, cmd_valid, rate_load}, 3'b100);

    ddr3_sel = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cmd_ready = 1'b1;
    repeat (30) @(negedge clk);
    chk(busy == 1'b1 && done == 1'b0, "R10 restart after done", {busy, done}, 2'b10);
    rst_n = 1'b0;
    @(negedge clk);
    chk({cmd_valid, busy, done, rate_load, dll_reset, ocd_default} == 6'b0,
        "R1 reset mid-sequence", {cmd_valid, busy, done, rate_load, dll_reset, ocd_default}, 0);
    cmd_ready = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule